// File: doc/BRIEF.md
# Shadow Memory Sync Arbiter

The block keeps a local shadow copy of a small target memory map and keeps a remote target in step with it over a narrow, handshaked byte link. The host sees a simple access port. Ordinary memory writes land in the shadow in the same cycle they are accepted. A background engine later pushes the changed bytes to the target, one byte per link transfer. Writes to the I/O-chip window are committed to the shadow and also forwarded to the target straight away. Reads of the volatile part of that window are fetched from the target. All other reads are answered from the shadow.

Every link transfer is one token: a 2-bit opcode, plus the address and data presented alongside it. The token is held until the target signals ready. A volatile read uses two link transactions: the request token and the returned byte. A bulk readback command walks an inclusive address range, wrapping at the top of the map. It copies each target byte into the shadow and cancels any pending sync for that byte.

Arbitration is a state machine with these states:
- `ST_IDLE`: picks the next job, in priority order volatile read, then I/O write, then bulk readback, then background sync.
- `ST_SYNC` and `ST_IO_WR`: hold a write token until the target is ready, then return to `ST_IDLE`.
- `ST_RD_REQ` to `ST_RD_WAIT` to `ST_DONE`: send a volatile read, wait for the returned byte, then complete the host access.
- `ST_BULK_REQ` and `ST_BULK_WAIT`: loop once per byte of a bulk readback, moving to `ST_DONE` after the last address.
- `ST_DONE`: completes the pending host access and always returns to `ST_IDLE`.

Top module: `shadow_sync_arb`

## Requirements
- R1: After reset no link token is offered (l_valid low), the shadow reads as all zeros and no byte is marked dirty.
- R2: A host write (h_op 01) outside the I/O window (0x30..0x3F) is accepted in the cycle it is presented while the arbiter is in ST_IDLE, ST_SYNC or ST_IO_WR. A later read returns the new value.
- R3: A memory write whose data differs from the shadow byte is later sent to the target as a sync token (l_op 00) carrying that address and the latest data. A write of an unchanged value produces no link traffic.
- R4: A host write inside the I/O window updates the shadow and sends an I/O-write token (l_op 01). When the arbiter next returns to idle, this token goes ahead of any dirty bytes still waiting.
- R5: A host read (h_op 00 or 11) of the volatile range 0x38..0x3B sends an I/O-read token (l_op 10) and keeps h_ready low until l_rvalid returns a byte. That byte is the read result, and the request goes ahead of pending sync bytes.
- R6: A read of any address outside the volatile range, including the rest of the I/O window, is answered from the shadow in the same cycle with no link token.
- R7: While l_valid is high and l_ready is low, the token (opcode, address, data) holds steady and l_valid stays high.
- R8: Dirty bytes are sent in ascending address order, starting one above the last address that was synced and wrapping from 0x3F to 0x00.
- R9: A bulk readback (h_op 10, start h_addr, inclusive end h_end) sends one l_op 11 token per address in order. Each returned byte is written into the shadow and the matching dirty bit is cleared. h_ready rises only after the last byte.
- R10: If a host write changes a byte in the same cycle a sync of that byte starts, or while that sync is in flight, the byte is sent again with the newer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_valid | input | 1 | Host request present |
| h_op | input | 2 | Host operation: 00 read, 01 write, 10 bulk readback, 11 read |
| h_addr | input | ADDR_W | Host address, or bulk start address |
| h_end | input | ADDR_W | Inclusive last address of a bulk readback |
| h_wdata | input | DATA_W | Host write data |
| h_ready | output | 1 | Host request completes on this edge |
| h_rdata | output | DATA_W | Read data, valid while h_ready is high |
| l_valid | output | 1 | Link token offered |
| l_op | output | 2 | Token opcode: 00 sync write, 01 I/O write, 10 I/O read, 11 bulk read |
| l_addr | output | ADDR_W | Token address |
| l_data | output | DATA_W | Token data (write tokens) |
| l_ready | input | 1 | Target accepts the token on this edge |
| l_rvalid | input | 1 | Target returns a read byte |
| l_rdata | input | DATA_W | Returned read byte |

## Verification
Two functions can act on the same byte in the same cycle. The first case is a host write that changes an address in the very cycle the scanner launches that address. The bench provokes it with two back-to-back writes to one address from idle, and passes only if the target sees both values in order and ends with the second. The second case is a host I/O write, volatile read or bulk command that is already waiting when a sync transfer finishes while dirty bytes remain. The target model stalls ready for several cycles to set this up, and the logged token order is compared with the priority rule.

// File: rtl/shadow_sync_pkg.sv
package shadow_sync_pkg;

    typedef enum logic [1:0] {
        TOK_SYNC_WR = 2'b00,
        TOK_IO_WR   = 2'b01,
        TOK_IO_RD   = 2'b10,
        TOK_BULK_RD = 2'b11
    } tok_e;

    typedef enum logic [1:0] {
        HOP_READ     = 2'b00,
        HOP_WRITE    = 2'b01,
        HOP_BULK     = 2'b10,
        HOP_READ_ALT = 2'b11
    } hop_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_IO_WR,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_BULK_REQ,
        ST_BULK_WAIT,
        ST_DONE
    } arb_state_e;

endpackage

// File: rtl/ssa_region.sv
module ssa_region #(
    parameter int ADDR_W = 6,
    parameter int IO_LO  = 'h30,
    parameter int IO_HI  = 'h3F,
    parameter int VOL_LO = 'h38,
    parameter int VOL_HI = 'h3B
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_io,
    output logic              is_vol
);
    logic in_io_win;
    logic in_vol_win;

    always_comb begin
        in_io_win  = (int'(addr) >= IO_LO) && (int'(addr) <= IO_HI);
        in_vol_win = (int'(addr) >= VOL_LO) && (int'(addr) <= VOL_HI);
        is_io      = in_io_win;
        is_vol     = in_io_win && in_vol_win;
    end
endmodule

// File: rtl/ssa_dirty_scan.sv
module ssa_dirty_scan #(
    parameter int ADDR_W = 6,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic [DEPTH-1:0]  dirty,
    input  logic [ADDR_W-1:0] ptr,
    output logic              found,
    output logic [ADDR_W-1:0] idx
);
    logic [ADDR_W-1:0] probe;

    // Descending walk so the smallest offset from ptr wins.
    always_comb begin
        found = 1'b0;
        idx   = ptr;
        probe = ptr;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            probe = ptr + ADDR_W'(i);
            if (dirty[probe]) begin
                found = 1'b1;
                idx   = probe;
            end
        end
    end
endmodule

// File: rtl/shadow_sync_arb.sv
module shadow_sync_arb
    import shadow_sync_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int IO_LO  = 'h30,
    parameter int IO_HI  = 'h3F,
    parameter int VOL_LO = 'h38,
    parameter int VOL_HI = 'h3B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_valid,
    input  logic [1:0]        h_op,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [ADDR_W-1:0] h_end,
    input  logic [DATA_W-1:0] h_wdata,
    output logic              h_ready,
    output logic [DATA_W-1:0] h_rdata,
    output logic              l_valid,
    output logic [1:0]        l_op,
    output logic [ADDR_W-1:0] l_addr,
    output logic [DATA_W-1:0] l_data,
    input  logic              l_ready,
    input  logic              l_rvalid,
    input  logic [DATA_W-1:0] l_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] shadow_q [DEPTH];
    logic [DEPTH-1:0]  dirty_q;

    arb_state_e        state_q, state_d;
    logic [ADDR_W-1:0] xa_q, xa_d, end_q, end_d, ptr_q, ptr_d;
    logic [DATA_W-1:0] xd_q, xd_d, hold_q, hold_d;

    logic              is_io, is_vol;
    logic              scan_found;
    logic [ADDR_W-1:0] scan_idx;

    ssa_region #(
        .ADDR_W(ADDR_W), .IO_LO(IO_LO), .IO_HI(IO_HI),
        .VOL_LO(VOL_LO), .VOL_HI(VOL_HI)
    ) region_i (
        .addr   (h_addr),
        .is_io  (is_io),
        .is_vol (is_vol)
    );

    ssa_dirty_scan #(.ADDR_W(ADDR_W)) scan_i (
        .dirty (dirty_q),
        .ptr   (ptr_q),
        .found (scan_found),
        .idx   (scan_idx)
    );

    // Request decode
    logic is_rd, is_wr, is_bulk, local_ok;
    logic local_wr, local_rd, io_wr_go, vol_rd_go, bulk_go, sync_go;

    always_comb begin
        is_rd     = (h_op == HOP_READ) || (h_op == HOP_READ_ALT);
        is_wr     = (h_op == HOP_WRITE);
        is_bulk   = (h_op == HOP_BULK);
        local_ok  = (state_q == ST_IDLE) || (state_q == ST_SYNC) || (state_q == ST_IO_WR);
        local_wr  = h_valid && is_wr && !is_io && local_ok;
        local_rd  = h_valid && is_rd && !is_vol && local_ok;
        vol_rd_go = h_valid && is_rd && is_vol && (state_q == ST_IDLE);
        io_wr_go  = h_valid && is_wr && is_io && (state_q == ST_IDLE);
        bulk_go   = h_valid && is_bulk && (state_q == ST_IDLE);
        sync_go   = (state_q == ST_IDLE) && !vol_rd_go && !io_wr_go && !bulk_go && scan_found;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        xa_d    = xa_q;
        xd_d    = xd_q;
        end_d   = end_q;
        ptr_d   = ptr_q;
        hold_d  = hold_q;
        unique case (state_q)
            ST_IDLE: begin
                if (vol_rd_go) begin
                    state_d = ST_RD_REQ;
                    xa_d    = h_addr;
                end else if (io_wr_go) begin
                    state_d = ST_IO_WR;
                    xa_d    = h_addr;
                    xd_d    = h_wdata;
                end else if (bulk_go) begin
                    state_d = ST_BULK_REQ;
                    xa_d    = h_addr;
                    end_d   = h_end;
                end else if (sync_go) begin
                    state_d = ST_SYNC;
                    xa_d    = scan_idx;
                    xd_d    = shadow_q[scan_idx];
                    ptr_d   = scan_idx + 1'b1;
                end
            end
            ST_SYNC, ST_IO_WR: if (l_ready) state_d = ST_IDLE;
            ST_RD_REQ:         if (l_ready) state_d = ST_RD_WAIT;
            ST_RD_WAIT: begin
                if (l_rvalid) begin
                    hold_d  = l_rdata;
                    state_d = ST_DONE;
                end
            end
            ST_BULK_REQ:       if (l_ready) state_d = ST_BULK_WAIT;
            ST_BULK_WAIT: begin
                if (l_rvalid) begin
                    hold_d = l_rdata;
                    if (xa_q == end_q) begin
                        state_d = ST_DONE;
                    end else begin
                        xa_d    = xa_q + 1'b1;
                        state_d = ST_BULK_REQ;
                    end
                end
            end
            ST_DONE:           state_d = ST_IDLE;
            default:           state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            xa_q    <= '0;
            xd_q    <= '0;
            end_q   <= '0;
            ptr_q   <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            xa_q    <= xa_d;
            xd_q    <= xd_d;
            end_q   <= end_d;
            ptr_q   <= ptr_d;
            hold_q  <= hold_d;
        end
    end

    // Shadow and dirty storage
    logic              sh_we, ret_we, dirty_set, dirty_clr;
    logic [ADDR_W-1:0] sh_wa, clr_a;
    logic [DATA_W-1:0] sh_wd;

    always_comb begin
        ret_we    = l_rvalid && ((state_q == ST_RD_WAIT) || (state_q == ST_BULK_WAIT));
        sh_we     = local_wr || io_wr_go || ret_we;
        sh_wa     = ret_we ? xa_q : h_addr;
        sh_wd     = ret_we ? l_rdata : h_wdata;
        dirty_set = local_wr && (h_wdata != shadow_q[h_addr]);
        dirty_clr = sync_go || (l_rvalid && (state_q == ST_BULK_WAIT));
        clr_a     = sync_go ? scan_idx : xa_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dirty_q <= '0;
            for (int i = 0; i < DEPTH; i++) shadow_q[i] <= '0;
        end else begin
            if (sh_we) shadow_q[sh_wa] <= sh_wd;
            if (dirty_clr) dirty_q[clr_a] <= 1'b0;
            if (dirty_set) dirty_q[h_addr] <= 1'b1;  // a new change wins over a launch clear
        end
    end

    // Outputs
    always_comb begin
        l_valid = 1'b0;
        l_op    = TOK_SYNC_WR;
        l_addr  = xa_q;
        l_data  = '0;
        unique case (state_q)
            ST_SYNC:     begin l_valid = 1'b1; l_op = TOK_SYNC_WR; l_data = xd_q; end
            ST_IO_WR:    begin l_valid = 1'b1; l_op = TOK_IO_WR;   l_data = xd_q; end
            ST_RD_REQ:   begin l_valid = 1'b1; l_op = TOK_IO_RD;   end
            ST_BULK_REQ: begin l_valid = 1'b1; l_op = TOK_BULK_RD; end
            default:     l_valid = 1'b0;
        endcase
        h_ready = local_wr || local_rd || io_wr_go || (state_q == ST_DONE);
        h_rdata = (state_q == ST_DONE) ? hold_q : shadow_q[h_addr];
    end
endmodule

// File: rtl/shadow_sync_arb_chk.sv
module shadow_sync_arb_chk #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int IO_LO  = 'h30,
    parameter int IO_HI  = 'h3F,
    parameter int VOL_LO = 'h38,
    parameter int VOL_HI = 'h3B
) (
    input logic              clk,
    input logic              rst_n,
    input logic              h_valid,
    input logic [1:0]        h_op,
    input logic [ADDR_W-1:0] h_addr,
    input logic              h_ready,
    input logic [DATA_W-1:0] h_rdata,
    input logic              l_valid,
    input logic [1:0]        l_op,
    input logic [ADDR_W-1:0] l_addr,
    input logic [DATA_W-1:0] l_data,
    input logic              l_ready,
    input logic              l_rvalid,
    input logic [DATA_W-1:0] l_rdata
);
    logic              ret_seen;
    logic [DATA_W-1:0] ret_byte;
    logic              l_in_io, l_in_vol, h_in_vol, h_is_rd;

    always_comb begin
        l_in_io  = (int'(l_addr) >= IO_LO) && (int'(l_addr) <= IO_HI);
        l_in_vol = (int'(l_addr) >= VOL_LO) && (int'(l_addr) <= VOL_HI);
        h_in_vol = (int'(h_addr) >= VOL_LO) && (int'(h_addr) <= VOL_HI);
        h_is_rd  = (h_op == 2'b00) || (h_op == 2'b11);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_seen <= 1'b0;
            ret_byte <= '0;
        end else if (l_rvalid) begin
            ret_seen <= 1'b1;
            ret_byte <= l_rdata;
        end
    end

    AST_LINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        l_valid && !l_ready |=> l_valid && $stable(l_op) && $stable(l_addr) && $stable(l_data)); // R7

    AST_SYNC_OUTSIDE_IO: assert property (@(posedge clk) disable iff (!rst_n)
        l_valid && (l_op == 2'b00) |-> !l_in_io); // R3

    AST_IOWR_INSIDE_IO: assert property (@(posedge clk) disable iff (!rst_n)
        l_valid && (l_op == 2'b01) |-> l_in_io); // R4

    AST_IORD_VOLATILE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        l_valid && (l_op == 2'b10) |-> l_in_vol); // R6

    AST_VOL_READ_FROM_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        h_valid && h_ready && h_is_rd && h_in_vol |-> ret_seen && (h_rdata == ret_byte)); // R5
endmodule

bind shadow_sync_arb shadow_sync_arb_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IO_LO(IO_LO), .IO_HI(IO_HI),
    .VOL_LO(VOL_LO), .VOL_HI(VOL_HI)
) chk_i (
    .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_op(h_op), .h_addr(h_addr),
    .h_ready(h_ready), .h_rdata(h_rdata), .l_valid(l_valid), .l_op(l_op),
    .l_addr(l_addr), .l_data(l_data), .l_ready(l_ready), .l_rvalid(l_rvalid),
    .l_rdata(l_rdata)
);

// File: tb/shadow_sync_arb_tb.sv
module shadow_sync_arb_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       h_valid = 1'b0;
    logic [1:0] h_op = 2'b00;
    logic [5:0] h_addr = '0;
    logic [5:0] h_end = '0;
    logic [7:0] h_wdata = '0;
    logic       h_ready;
    logic [7:0] h_rdata;
    logic       l_valid;
    logic [1:0] l_op;
    logic [5:0] l_addr;
    logic [7:0] l_data;
    logic       l_ready = 1'b0;
    logic       l_rvalid = 1'b0;
    logic [7:0] l_rdata = '0;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    shadow_sync_arb dut_i (
        .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_op(h_op), .h_addr(h_addr),
        .h_end(h_end), .h_wdata(h_wdata), .h_ready(h_ready), .h_rdata(h_rdata),
        .l_valid(l_valid), .l_op(l_op), .l_addr(l_addr), .l_data(l_data),
        .l_ready(l_ready), .l_rvalid(l_rvalid), .l_rdata(l_rdata)
    );

    // Target model: stalls ready, logs tokens, returns read bytes after two edges
    logic [7:0] tgt_mem [64];
    logic [1:0] log_op [256];
    logic [5:0] log_addr [256];
    logic [7:0] log_data [256];
    int         log_n = 0;
    int         stall = 0;
    int         wait_cnt = 0;
    int         rd_cnt = 0;
    int         drop_viol = 0;
    logic [5:0] rd_addr = '0;
    logic       prev_pend = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            l_ready   <= 1'b0;
            l_rvalid  <= 1'b0;
            wait_cnt  <= 0;
            rd_cnt    <= 0;
            prev_pend <= 1'b0;
        end else begin
            l_rvalid <= 1'b0;
            if (rd_cnt == 1) begin
                l_rvalid <= 1'b1;
                l_rdata  <= tgt_mem[rd_addr];
            end
            if (rd_cnt > 0) rd_cnt <= rd_cnt - 1;
            if (prev_pend && !l_valid) drop_viol <= drop_viol + 1;
            if (l_valid && l_ready) begin
                log_op[log_n]   <= l_op;
                log_addr[log_n] <= l_addr;
                log_data[log_n] <= l_data;
                log_n           <= log_n + 1;
                if (l_op == 2'b00 || l_op == 2'b01) begin
                    tgt_mem[l_addr] <= l_data;
                end else begin
                    rd_cnt  <= 2;
                    rd_addr <= l_addr;
                end
                l_ready   <= 1'b0;
                wait_cnt  <= 0;
                prev_pend <= 1'b0;
            end else if (l_valid) begin
                prev_pend <= 1'b1;
                if (wait_cnt >= stall) l_ready <= 1'b1;
                else wait_cnt <= wait_cnt + 1;
            end else begin
                prev_pend <= 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_log(input string req, input int idx, input logic [1:0] op,
                           input logic [5:0] a);
        chk(req, {24'h0, log_op[idx], log_addr[idx]}, {24'h0, op, a});
    endtask

    task automatic host_do(input logic [1:0] op, input logic [5:0] a, input logic [7:0] d,
                           input logic [5:0] e, output logic [7:0] rd, output int waits);
        logic done;
        rd    = '0;
        waits = 0;
        done  = 1'b0;
        @(negedge clk);
        h_valid = 1'b1; h_op = op; h_addr = a; h_wdata = d; h_end = e;
        while (!done) begin
            #2;
            if (h_ready) begin
                rd   = h_rdata;
                done = 1'b1;
                @(posedge clk);
                #1;
                h_valid = 1'b0;
            end else begin
                waits++;
                @(negedge clk);
            end
        end
    endtask

    // {op, addr, wdata, expected read, compare}
    localparam logic [24:0] VEC [10] = '{
        {2'd1, 6'h05, 8'hA1, 8'h00, 1'b0},
        {2'd1, 6'h06, 8'hB2, 8'h00, 1'b0},
        {2'd0, 6'h05, 8'h00, 8'hA1, 1'b1},
        {2'd3, 6'h06, 8'h00, 8'hB2, 1'b1},
        {2'd1, 6'h10, 8'h00, 8'h00, 1'b0},
        {2'd0, 6'h10, 8'h00, 8'h00, 1'b1},
        {2'd0, 6'h34, 8'h00, 8'h00, 1'b1},
        {2'd1, 6'h05, 8'hC3, 8'h00, 1'b0},
        {2'd0, 6'h05, 8'h00, 8'hC3, 1'b1},
        {2'd0, 6'h3E, 8'h00, 8'h00, 1'b1}
    };

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int w, base, cnt;
        for (int i = 0; i < 64; i++) tgt_mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 l_valid in reset", {31'h0, l_valid}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 l_valid after reset", {31'h0, l_valid}, 32'h0);
        host_do(2'd0, 6'h00, 8'h00, 6'h00, rd, w);
        chk("R1 shadow zero", {24'h0, rd}, 32'h0);
        repeat (10) @(posedge clk);
        chk("R1 no dirty after reset", log_n, 0);

        // Table of shadow accesses (R2, R6)
        for (int i = 0; i < 10; i++) begin
            host_do(VEC[i][24:23], VEC[i][22:17], VEC[i][16:9], 6'h00, rd, w);
            if (VEC[i][0]) chk("R2 table read", {24'h0, rd}, {24'h0, VEC[i][8:1]});
            if (VEC[i][24:23] == 2'd1) chk("R2 write accepted at once", w, 0);
        end
        repeat (60) @(posedge clk);
        chk("R3 target got latest 05", {24'h0, tgt_mem[5]}, 32'hC3);
        chk("R3 target got 06", {24'h0, tgt_mem[6]}, 32'hB2);
        cnt = 0;
        for (int i = 0; i < log_n; i++) if (log_addr[i] == 6'h10 || log_op[i] == 2'b10) cnt++;
        chk("R3 R6 no token for unchanged write or shadow read", cnt, 0);

        // R4: I/O write overtakes waiting sync bytes
        stall = 6;
        base = log_n;
        host_do(2'd1, 6'h01, 8'h11, 6'h00, rd, w);
        host_do(2'd1, 6'h02, 8'h22, 6'h00, rd, w);
        host_do(2'd1, 6'h03, 8'h33, 6'h00, rd, w);
        host_do(2'd1, 6'h31, 8'h44, 6'h00, rd, w);
        repeat (100) @(posedge clk);
        chk_log("R4 order 0", base + 0, 2'b00, 6'h01);
        chk_log("R4 order 1", base + 1, 2'b01, 6'h31);
        chk_log("R4 order 2", base + 2, 2'b00, 6'h02);
        chk_log("R4 order 3", base + 3, 2'b00, 6'h03);
        chk("R4 target io byte", {24'h0, tgt_mem[6'h31]}, 32'h44);
        host_do(2'd0, 6'h31, 8'h00, 6'h00, rd, w);
        chk("R4 R6 io byte in shadow", {24'h0, rd}, 32'h44);
        chk("R6 shadow read no wait", w, 0);

        // R5: volatile read overtakes waiting sync bytes
        tgt_mem[6'h39] = 8'h5A;
        base = log_n;
        host_do(2'd1, 6'h0A, 8'h01, 6'h00, rd, w);
        host_do(2'd1, 6'h0B, 8'h02, 6'h00, rd, w);
        host_do(2'd0, 6'h39, 8'h00, 6'h00, rd, w);
        chk("R5 volatile data", {24'h0, rd}, 32'h5A);
        chk("R5 host held", {31'h0, w >= 3}, 32'h1);
        repeat (60) @(posedge clk);
        chk_log("R5 order 0", base + 0, 2'b00, 6'h0A);
        chk_log("R5 order 1", base + 1, 2'b10, 6'h39);
        chk_log("R5 order 2", base + 2, 2'b00, 6'h0B);
        chk("R7 target byte under stall", {24'h0, tgt_mem[6'h0A]}, 32'h01);
        chk("R7 token never dropped", drop_viol, 0);

        // R10: rewrite in the launch cycle
        base = log_n;
        host_do(2'd1, 6'h07, 8'h01, 6'h00, rd, w);
        host_do(2'd1, 6'h07, 8'h02, 6'h00, rd, w);
        repeat (60) @(posedge clk);
        chk("R10 two sync tokens", log_n - base, 2);
        chk("R10 first value", {24'h0, log_data[base]}, 32'h01);
        chk("R10 second value", {24'h0, log_data[base + 1]}, 32'h02);
        chk("R10 target final", {24'h0, tgt_mem[7]}, 32'h02);

        // R8: rotating order, pointer left at 0x2B
        stall = 0;
        host_do(2'd1, 6'h2A, 8'h01, 6'h00, rd, w);
        repeat (20) @(posedge clk);
        stall = 6;
        base = log_n;
        host_do(2'd1, 6'h05, 8'h11, 6'h00, rd, w);
        host_do(2'd1, 6'h2C, 8'h12, 6'h00, rd, w);
        host_do(2'd1, 6'h03, 8'h13, 6'h00, rd, w);
        host_do(2'd1, 6'h28, 8'h14, 6'h00, rd, w);
        repeat (100) @(posedge clk);
        chk_log("R8 order 0", base + 0, 2'b00, 6'h05);
        chk_log("R8 order 1", base + 1, 2'b00, 6'h28);
        chk_log("R8 order 2", base + 2, 2'b00, 6'h2C);
        chk_log("R8 order 3", base + 3, 2'b00, 6'h03);

        // R9: bulk readback cancels a waiting sync
        stall = 2;
        tgt_mem[6'h0C] = 8'hC1; tgt_mem[6'h0D] = 8'hD1;
        tgt_mem[6'h0E] = 8'hE1; tgt_mem[6'h0F] = 8'hF1;
        base = log_n;
        host_do(2'd1, 6'h0D, 8'h77, 6'h00, rd, w);
        host_do(2'd1, 6'h0E, 8'h88, 6'h00, rd, w);
        host_do(2'd2, 6'h0C, 8'h00, 6'h0F, rd, w);
        chk("R9 bulk last byte", {24'h0, rd}, 32'hF1);
        repeat (60) @(posedge clk);
        chk("R9 token count", log_n - base, 5);
        chk_log("R9 sync first", base + 0, 2'b00, 6'h0D);
        for (int k = 0; k < 4; k++) chk_log("R9 bulk token", base + 1 + k, 2'b11, 6'h0C + 6'(k));
        host_do(2'd0, 6'h0E, 8'h00, 6'h00, rd, w);
        chk("R9 shadow took target byte", {24'h0, rd}, 32'hE1);
        host_do(2'd0, 6'h0D, 8'h00, 6'h00, rd, w);
        chk("R9 synced byte read back", {24'h0, rd}, 32'h77);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule